// File: doc/BRIEF.md
# Speculative Load Wakeup Tracker

This block is a small slice of an out-of-order issue queue. Each entry holds an instruction's source-operand tags and a small ready state per operand. It does not hold operand data, because registers are read after issue. An entry asks to issue once none of its operands is still waiting. Each cycle, one requester is granted, and the lowest-numbered slot wins.

When a load issues on the assumption that it hits, the pipeline raises a speculative wakeup carrying the load's destination tag. Operands that wait on that tag become speculatively ready at once, so their consumers can issue one cycle later. In that same cycle the cache reports hit or miss.

- On a hit, the speculative operands become confirmed, and any consumer issued on them leaves the queue.
- On a miss, each consumer issued in that cycle receives a kill pulse on the next cycle and stays allocated. Every speculative operand drops back to waiting until a normal wakeup for its tag arrives. A normal wakeup always confirms a matching operand, whatever its state.

Each operand is a three-state machine:

- `OP_WAIT` goes to `OP_READY` on a normal wakeup, or to `OP_SPEC` on a speculative wakeup.
- `OP_SPEC` goes to `OP_READY` on a normal wakeup or a hit. It goes back to `OP_WAIT` on a miss.
- `OP_READY` holds.

Allocation overrides all of these. Each entry is a two-state machine:

- `E_FREE` goes to `E_HELD` on allocation.
- `E_HELD` goes to `E_FREE` on a grant that is not killed.

A shadow machine opens for the one cycle after every speculative wakeup:

- `SH_IDLE` goes to `SH_OPEN` on a speculative wakeup.
- `SH_OPEN` goes to `SH_OPEN` on another speculative wakeup, or back to `SH_IDLE` otherwise.

The hit/miss input is only heard while the shadow is open.

Top module: `spec_wake_iq`

## Requirements
- R1: Out of reset all entries are free, `req_vec` and `kill_vec` are zero and `full` is low.
- R2: A request on `alloc_valid` fills the lowest-numbered free entry, which is held from the next cycle. `full` is high while all entries are held. An allocation while `full` is high is dropped.
- R3: `req_vec[i]` is high while entry i is held and none of its operands is waiting. An operand allocated with its `alloc_rdy` bit set counts as ready.
- R4: `grant_vec` is combinational from `req_vec`. It is one-hot or zero and selects the lowest-indexed requester.
- R5: A normal wakeup (`wake_valid`, `wake_tag`) makes every operand whose tag equals `wake_tag` ready from the next cycle, whatever its state. This includes an operand being allocated in the same cycle.
- R6: A speculative wakeup (`spec_valid`, `spec_tag`) makes every waiting operand whose tag equals `spec_tag` speculatively ready from the next cycle, which is enough for its entry to request. This includes an operand being allocated in the same cycle.
- R7: `ld_hit` is sampled in the cycle after a speculative wakeup. When it is high, all speculatively ready operands become ready.
- R8: When `ld_hit` is low in that cycle, the following happens together:
  - Every speculatively ready operand returns to waiting, unless a matching normal wakeup arrives in the same cycle.
  - A granted entry with a speculative operand stays held.
  - That entry's `kill_vec` bit is high for exactly the next cycle.
- R9: A granted entry that is not killed is free from the next cycle, and its request bit falls.
- R10: `ld_hit` has no effect in a cycle not preceded by a speculative wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an instruction this cycle |
| alloc_tags | input | SRCS*TAG_W | Source tags, operand s at bits [s*TAG_W +: TAG_W] |
| alloc_rdy | input | SRCS | Per-operand ready-at-allocation flags |
| wake_valid | input | 1 | Normal (confirmed) wakeup strobe |
| wake_tag | input | TAG_W | Tag of the normal wakeup |
| spec_valid | input | 1 | Speculative load wakeup strobe |
| spec_tag | input | TAG_W | Destination tag of the speculatively woken load |
| ld_hit | input | 1 | Hit (1) or miss (0) of the load woken in the previous cycle |
| full | output | 1 | All entries are held |
| req_vec | output | ENTRIES | Issue requests, bit i for entry i |
| grant_vec | output | ENTRIES | Issue grant, lowest-index requester |
| kill_vec | output | ENTRIES | Kill pulse for an entry issued on a missed load |

## Verification
`req_vec` and `full` change one edge after the allocation, wakeup or grant that causes them. `grant_vec` follows `req_vec` in the same cycle. `kill_vec` rises one edge after the miss and falls one edge later. Counted from the speculative wakeup, a dependent requests one cycle later and is killed two cycles later.

The bench drives inputs on the falling edge and keeps a model that advances once per rising edge. It compares all four outputs at the next falling edge, once every register on the path has settled. Directed sequences pin these delays to literal values before a long pseudo-random sweep over a narrow tag range, which makes matches frequent.

// File: rtl/siq_pkg.sv
package siq_pkg;
    typedef enum logic [1:0] {OP_WAIT, OP_SPEC, OP_READY} op_state_t;
    typedef enum logic {E_FREE, E_HELD} ent_state_t;
    typedef enum logic {SH_IDLE, SH_OPEN} sh_state_t;
endpackage

// File: rtl/siq_shadow.sv
module siq_shadow
    import siq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic spec_valid,
    input  logic ld_hit,
    output logic confirm,
    output logic revert
);
    sh_state_t st_q, st_d;

    always_comb begin
        st_d = spec_valid ? SH_OPEN : SH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SH_IDLE;
        else        st_q <= st_d;
    end

    // hit/miss is only meaningful in the cycle after a speculative wakeup
    always_comb begin
        confirm = 1'b0;
        revert  = 1'b0;
        unique case (st_q)
            SH_IDLE: ;
            SH_OPEN: begin
                confirm = ld_hit;
                revert  = !ld_hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/siq_pick.sv
module siq_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign pick[i]   = req[i] & ~seen[i];
    end

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick)); // R4
    AST_PICK_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ((pick & req) != '0)); // R4
endmodule

// File: rtl/siq_operand.sv
module siq_operand
    import siq_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             load_rdy,
    input  logic             wake_valid,
    input  logic [TAG_W-1:0] wake_tag,
    input  logic             spec_valid,
    input  logic [TAG_W-1:0] spec_tag,
    input  logic             confirm,
    input  logic             revert,
    output op_state_t        state
);
    logic [TAG_W-1:0] tag_q;
    op_state_t        state_d;
    logic             wake_hit, spec_hit;

    assign wake_hit = wake_valid && (wake_tag == tag_q);
    assign spec_hit = spec_valid && (spec_tag == tag_q);

    always_comb begin
        state_d = state;
        if (load) begin
            if (load_rdy || (wake_valid && wake_tag == load_tag)) state_d = OP_READY;
            else if (spec_valid && spec_tag == load_tag)          state_d = OP_SPEC;
            else                                                  state_d = OP_WAIT;
        end else begin
            unique case (state)
                OP_WAIT: begin
                    if (wake_hit)      state_d = OP_READY;
                    else if (spec_hit) state_d = OP_SPEC;
                end
                OP_SPEC: begin
                    if (wake_hit || confirm) state_d = OP_READY;
                    else if (revert)         state_d = OP_WAIT;
                end
                OP_READY: ;
                default: state_d = OP_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OP_WAIT;
            tag_q <= '0;
        end else begin
            state <= state_d;
            if (load) tag_q <= load_tag;
        end
    end

    AST_SPEC_IN_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OP_SPEC) |-> (confirm || revert)); // R7
endmodule

// File: rtl/spec_wake_iq.sv
module spec_wake_iq
    import siq_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int SRCS    = 2,
    parameter int TAG_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_valid,
    input  logic [SRCS*TAG_W-1:0] alloc_tags,
    input  logic [SRCS-1:0]       alloc_rdy,
    input  logic                  wake_valid,
    input  logic [TAG_W-1:0]      wake_tag,
    input  logic                  spec_valid,
    input  logic [TAG_W-1:0]      spec_tag,
    input  logic                  ld_hit,
    output logic                  full,
    output logic [ENTRIES-1:0]    req_vec,
    output logic [ENTRIES-1:0]    grant_vec,
    output logic [ENTRIES-1:0]    kill_vec
);
    logic               confirm, revert;
    ent_state_t         ent_q [ENTRIES];
    ent_state_t         ent_d [ENTRIES];
    op_state_t          op_st [ENTRIES][SRCS];
    logic [ENTRIES-1:0] free_vec, slot_pick, alloc_sel, doomed;

    siq_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .spec_valid(spec_valid), .ld_hit(ld_hit),
        .confirm(confirm), .revert(revert)
    );

    siq_pick #(.N(ENTRIES)) u_issue (
        .clk(clk), .rst_n(rst_n), .req(req_vec), .pick(grant_vec)
    );

    siq_pick #(.N(ENTRIES)) u_slot (
        .clk(clk), .rst_n(rst_n), .req(free_vec), .pick(slot_pick)
    );

    assign alloc_sel = slot_pick & {ENTRIES{alloc_valid}};
    assign full      = ~|free_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic any_spec, any_wait;

        for (genvar s = 0; s < SRCS; s++) begin : g_src
            siq_operand #(.TAG_W(TAG_W)) u_op (
                .clk(clk), .rst_n(rst_n),
                .load(alloc_sel[i]),
                .load_tag(alloc_tags[s*TAG_W +: TAG_W]),
                .load_rdy(alloc_rdy[s]),
                .wake_valid(wake_valid), .wake_tag(wake_tag),
                .spec_valid(spec_valid), .spec_tag(spec_tag),
                .confirm(confirm), .revert(revert),
                .state(op_st[i][s])
            );
        end

        always_comb begin
            any_spec = 1'b0;
            any_wait = 1'b0;
            for (int s = 0; s < SRCS; s++) begin
                if (op_st[i][s] == OP_SPEC) any_spec = 1'b1;
                if (op_st[i][s] == OP_WAIT) any_wait = 1'b1;
            end
        end

        assign free_vec[i] = (ent_q[i] == E_FREE);
        assign req_vec[i]  = (ent_q[i] == E_HELD) && !any_wait;
        assign doomed[i]   = grant_vec[i] && revert && any_spec;

        always_comb begin
            ent_d[i] = ent_q[i];
            unique case (ent_q[i])
                E_FREE: if (alloc_sel[i]) ent_d[i] = E_HELD;
                E_HELD: if (grant_vec[i] && !doomed[i]) ent_d[i] = E_FREE;
                default: ent_d[i] = E_FREE;
            endcase
        end

        AST_KILL_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            kill_vec[i] |-> (ent_q[i] == E_HELD)); // R8
        AST_KILL_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
            kill_vec[i] |-> $past(revert)); // R8
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= E_FREE;
            kill_vec <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
            kill_vec <= doomed;
        end
    end
endmodule

// File: tb/sim_spec_wake_iq.sv
module sim_spec_wake_iq;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int S  = 2;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [S*TW-1:0] alloc_tags = '0;
    logic [S-1:0]  alloc_rdy = '0;
    logic          wake_valid = 1'b0;
    logic [TW-1:0] wake_tag = '0;
    logic          spec_valid = 1'b0;
    logic [TW-1:0] spec_tag = '0;
    logic          ld_hit = 1'b0;
    logic          full;
    logic [N-1:0]  req_vec, grant_vec, kill_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int mval [N];
    int mst  [N][S];
    int mtag [N][S];
    int mpend = 0;
    int mkill [N];
    logic [31:0] seed = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_wake_iq #(.ENTRIES(N), .SRCS(S), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tags(alloc_tags), .alloc_rdy(alloc_rdy),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .spec_valid(spec_valid), .spec_tag(spec_tag), .ld_hit(ld_hit),
        .full(full), .req_vec(req_vec), .grant_vec(grant_vec), .kill_vec(kill_vec)
    );

    task automatic check(input string rid, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rid, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] nextrand();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    // Called just after a falling edge: compare outputs with model, drive, advance model.
    task automatic step(input logic av, input logic [S*TW-1:0] at, input logic [S-1:0] ar,
                        input logic wv, input logic [TW-1:0] wt,
                        input logic sv, input logic [TW-1:0] st, input logic hit);
        int er, eg, ef, ek, tgt;
        bit miss, okhit;
        er = 0; eg = 0; ef = 1; ek = 0;
        for (int i = 0; i < N; i++) begin
            bit nowait;
            nowait = 1'b1;
            for (int s = 0; s < S; s++) if (mst[i][s] == 0) nowait = 1'b0;
            if (mval[i] != 0 && nowait) er |= (1 << i);
            if (mval[i] == 0) ef = 0;
            if (mkill[i] != 0) ek |= (1 << i);
        end
        for (int i = 0; i < N; i++) if (eg == 0 && ((er >> i) & 1) != 0) eg = (1 << i);
        check("R3 req_vec", int'(req_vec), er);
        check("R4 grant_vec", int'(grant_vec), eg);
        check("R8 kill_vec", int'(kill_vec), ek);
        check("R2 full", int'(full), ef);

        alloc_valid = av; alloc_tags = at; alloc_rdy = ar;
        wake_valid = wv; wake_tag = wt; spec_valid = sv; spec_tag = st; ld_hit = hit;

        miss  = (mpend != 0) && !hit;
        okhit = (mpend != 0) && hit;
        tgt = -1;
        if (av) for (int i = N - 1; i >= 0; i--) if (mval[i] == 0) tgt = i;
        for (int i = 0; i < N; i++) begin
            bit hs;
            hs = 1'b0;
            for (int s = 0; s < S; s++) if (mst[i][s] == 1) hs = 1'b1;
            mkill[i] = (((eg >> i) & 1) != 0 && miss && hs) ? 1 : 0;
            if (mval[i] != 0 && ((eg >> i) & 1) != 0 && !(miss && hs)) mval[i] = 0;
            else if (mval[i] == 0 && i == tgt) mval[i] = 1;
            for (int s = 0; s < S; s++) begin
                int tg;
                if (i == tgt) begin
                    tg = int'(at[s*TW +: TW]);
                    mtag[i][s] = tg;
                    if (ar[s] || (wv && int'(wt) == tg)) mst[i][s] = 2;
                    else if (sv && int'(st) == tg)      mst[i][s] = 1;
                    else                                 mst[i][s] = 0;
                end else begin
                    tg = mtag[i][s];
                    if (mst[i][s] == 0) begin
                        if (wv && int'(wt) == tg)      mst[i][s] = 2;
                        else if (sv && int'(st) == tg) mst[i][s] = 1;
                    end else if (mst[i][s] == 1) begin
                        if ((wv && int'(wt) == tg) || okhit) mst[i][s] = 2;
                        else if (miss)                      mst[i][s] = 0;
                    end
                end
            end
        end
        mpend = sv ? 1 : 0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, '0, '0, 0, '0, 0, '0, 0);
    endtask

    function automatic logic [S*TW-1:0] tags2(input int a, input int b);
        return {TW'(b), TW'(a)};
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            mval[i] = 0; mkill[i] = 0;
            for (int s = 0; s < S; s++) begin mst[i][s] = 0; mtag[i][s] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 req after reset", int'(req_vec), 0);
        check("R1 kill after reset", int'(kill_vec), 0);
        check("R1 full after reset", int'(full), 0);

        // R3: waiting operand blocks the request
        step(1, tags2(5, 6), 2'b10, 0, '0, 0, '0, 0);
        check("R3 waiting operand no request", int'(req_vec), 0);
        // R3/R4: fully ready entry in slot 1 requests and is granted
        step(1, tags2(7, 7), 2'b11, 0, '0, 0, '0, 0);
        check("R3 ready entry requests", int'(req_vec), 4'b0010);
        check("R4 grant lowest requester", int'(grant_vec), 4'b0010);
        // R6: speculative wakeup of tag 5
        step(0, '0, '0, 0, '0, 1, 4'd5, 0);
        check("R6 speculative wake enables request", int'(req_vec), 4'b0001);
        check("R9 granted entry freed", int'(req_vec[1]), 0);
        // R8: miss
        step(0, '0, '0, 0, '0, 0, '0, 0);
        check("R8 kill pulse after miss", int'(kill_vec), 4'b0001);
        check("R8 operand back to waiting", int'(req_vec), 0);
        // R10: stray hit with no open shadow
        step(0, '0, '0, 0, '0, 0, '0, 1);
        check("R8 kill lasts one cycle", int'(kill_vec), 0);
        check("R10 stray hit ignored", int'(req_vec), 0);
        // R5: real wakeup re-enables the killed entry
        step(0, '0, '0, 1, 4'd5, 0, '0, 0);
        check("R5 real wake after kill", int'(req_vec), 4'b0001);
        step(0, '0, '0, 0, '0, 0, '0, 0);
        check("R9 issued entry leaves", int'(req_vec), 0);

        // R7: hit confirms two dependents
        step(1, tags2(8, 0), 2'b10, 0, '0, 0, '0, 0);
        step(1, tags2(8, 0), 2'b10, 0, '0, 0, '0, 0);
        step(0, '0, '0, 0, '0, 1, 4'd8, 0);
        check("R6 both dependents request", int'(req_vec), 4'b0011);
        step(0, '0, '0, 0, '0, 0, '0, 1);
        check("R7 hit confirms, no kill", int'(kill_vec), 0);
        check("R7 unissued dependent ready", int'(req_vec), 4'b0010);
        idle(2);

        // R5: wakeup in same cycle as allocation
        step(1, tags2(10, 10), 2'b00, 1, 4'd10, 0, '0, 0);
        check("R5 wake during allocation", int'(req_vec), 4'b0001);
        idle(2);

        // R2: fill, drop when full
        for (int k = 0; k < N; k++) step(1, tags2(11, 11), 2'b00, 0, '0, 0, '0, 0);
        check("R2 full after filling", int'(full), 1);
        step(1, tags2(1, 1), 2'b11, 0, '0, 0, '0, 0);
        check("R2 allocation dropped when full", int'(req_vec), 0);
        step(0, '0, '0, 1, 4'd11, 0, '0, 0);
        check("R5 all woken", int'(req_vec), 4'b1111);
        idle(N + 1);
        check("R9 queue drained", int'(full), 0);

        // R8/R5: miss with same-cycle real wakeup
        step(1, tags2(12, 12), 2'b00, 0, '0, 0, '0, 0);
        step(0, '0, '0, 0, '0, 1, 4'd12, 0);
        step(0, '0, '0, 1, 4'd12, 0, '0, 0);
        check("R8 kill despite real wake", int'(kill_vec), 4'b0001);
        check("R5 real wake beats miss", int'(req_vec), 4'b0001);
        idle(3);

        // Pseudo-random sweep over a narrow tag range
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = nextrand();
            step(r[1:0] != 2'b00, tags2(int'(r[3:2]), int'(r[5:4])), (r[8:6] == 3'b000) ? 2'b11 :
                 {r[9] & r[10], r[11] & r[12]},
                 r[15:13] == 3'b000, TW'(r[17:16]),
                 r[20:18] < 3'd3, TW'(r[22:21]), r[23]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule